// File: doc/BRIEF.md
# Banked Execution Priority Calculator

This block works out the execution priority of a processor core that runs in two security states, Secure and Non-secure. Each state has its own copy of three masking controls: a base threshold, an interrupt mask bit and a fault mask bit. Every one of the six copies can raise the urgency of the current context. The block starts from the group priority of the highest active exception. It then folds in each enabled mask as a conditional override, and the running value is replaced only by a strictly more urgent (numerically smaller) candidate. Priorities are signed. Lower values are more urgent, the range runs from -3 up to 256, and 256 means idle.

Two control inputs reshape the Non-secure side. The split control compresses Non-secure priorities into the lower-urgency half of the range. The fault-ownership control gives Non-secure the fault-handling role, and it also moves the level that a Secure fault mask imposes. Each state also has its own grouping field, which selects how many upper bits of a base threshold form the group priority. A second output compares a pending exception's group priority with the execution priority and reports whether it would preempt. Both outputs are registered and appear one clock after the inputs.

Top module: `exec_prio_calc`

## Requirements
- R1: While reset is asserted, exec_prio reads 256 and preempt reads 0, whatever the inputs are.
- R2: With all six masks inactive and both thresholds zero, exec_prio equals act_prio one clock after the inputs are applied.
- R3: A Secure threshold of zero has no effect. A nonzero Secure threshold is first ANDed with the group mask of grp_s, which keeps bits [7:g+1] for grouping value g and keeps none for g=7. The masked value is a candidate even when it is zero. A Non-secure threshold is masked with grp_ns in the same way when ns_split is 0.
- R4: When ns_split is 1, a nonzero Non-secure threshold is group-masked, then remapped to (v >> 1) | 0x80 before it is used.
- R5: An active Secure interrupt mask gives candidate 0. An active Non-secure interrupt mask gives 0x80 when ns_split is 1, and 0 otherwise.
- R6: An active Secure fault mask gives -3 when ns_fault_own is 1, and -1 otherwise.
- R7: An active Non-secure fault mask gives -1 when ns_fault_own is 1. Otherwise it gives 0x80 when ns_split is 1, and 0 when ns_split is 0.
- R8: exec_prio is the most urgent of act_prio and every active candidate. It is never less urgent than act_prio. A candidate does not win just because it belongs to a mask kind applied later.
- R9: preempt is 1 exactly when pend_prio is strictly less than exec_prio, with both values taken from the same input cycle. Equal values do not preempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_prio | input | 10 | Signed group priority of the highest active exception (256 when none) |
| thr_s | input | 8 | Secure base threshold (0 = off) |
| thr_ns | input | 8 | Non-secure base threshold (0 = off) |
| imask_s | input | 1 | Secure interrupt mask |
| imask_ns | input | 1 | Non-secure interrupt mask |
| fltmask_s | input | 1 | Secure fault mask |
| fltmask_ns | input | 1 | Non-secure fault mask |
| ns_split | input | 1 | Compress Non-secure priorities into the 0x80..0xFF half |
| ns_fault_own | input | 1 | Non-secure owns the fault-handling role |
| grp_s | input | 3 | Secure priority grouping |
| grp_ns | input | 3 | Non-secure priority grouping |
| pend_prio | input | 10 | Signed group priority of the pending exception |
| exec_prio | output | 10 | Signed execution priority, registered |
| preempt | output | 1 | Pending exception would preempt, registered |

## Verification
The interesting collisions come from two mask kinds of different states that are active in the same cycle. A typical case is a Non-secure interrupt mask remapped to 0x80 by the split control, next to a Secure threshold that is more urgent. A fixed mask precedence would pick the interrupt mask, but the correct answer is the threshold. The bench provokes these by sweeping every combination of the four mask bits, the two control bits and several threshold, grouping and active-priority values. A model written from the requirements judges each result and names the requirement of the winning candidate. The preempt decision is judged in the same cycle against the priority that was just produced, including the equal-priority boundary.

// File: rtl/epc_pkg.sv
package epc_pkg;

    parameter int PRIO_W = 8;
    parameter int GRP_W  = 3;
    parameter int RES_W  = PRIO_W + 2;
    parameter int N_CAND = 6;

    typedef logic signed [RES_W-1:0] eprio_t;

    localparam eprio_t IDLE_PRIO = eprio_t'(1 << PRIO_W);

    // candidate kinds, in the order the overrides are applied
    typedef enum logic [2:0] {
        K_THR_NS   = 3'd0,
        K_THR_S    = 3'd1,
        K_IMASK_NS = 3'd2,
        K_IMASK_S  = 3'd3,
        K_FLT_NS   = 3'd4,
        K_FLT_S    = 3'd5
    } cand_kind_e;

endpackage

// File: rtl/epc_group_mask.sv
module epc_group_mask
    import epc_pkg::*;
(
    input  logic [GRP_W-1:0]  grp,
    output logic [PRIO_W-1:0] keep
);

    localparam int EXT_W = PRIO_W + 1;

    logic [EXT_W-1:0] low_ones;
    logic [GRP_W:0]   shift_amt;

    always_comb begin
        shift_amt = {1'b0, grp} + (GRP_W+1)'(1);
        low_ones  = (EXT_W'(1) << shift_amt) - EXT_W'(1);
        keep      = ~low_ones[PRIO_W-1:0];
    end

endmodule

// File: rtl/epc_candidates.sv
module epc_candidates
    import epc_pkg::*;
(
    input  logic [PRIO_W-1:0] thr_s,
    input  logic [PRIO_W-1:0] thr_ns,
    input  logic              imask_s,
    input  logic              imask_ns,
    input  logic              fltmask_s,
    input  logic              fltmask_ns,
    input  logic              ns_split,
    input  logic              ns_fault_own,
    input  logic [GRP_W-1:0]  grp_s,
    input  logic [GRP_W-1:0]  grp_ns,
    output eprio_t            cand [N_CAND],
    output logic [N_CAND-1:0] live
);

    localparam logic [PRIO_W-1:0] HALF = {1'b1, {(PRIO_W-1){1'b0}}};

    logic [PRIO_W-1:0] keep_s, keep_ns;
    logic [PRIO_W-1:0] gthr_s, gthr_ns, mapped_ns;
    logic [PRIO_W-1:0] ns_mask_lvl;

    epc_group_mask u_gm_s  (.grp(grp_s),  .keep(keep_s));
    epc_group_mask u_gm_ns (.grp(grp_ns), .keep(keep_ns));

    assign gthr_s      = thr_s  & keep_s;
    assign gthr_ns     = thr_ns & keep_ns;
    assign mapped_ns   = ns_split ? {1'b1, gthr_ns[PRIO_W-1:1]} : gthr_ns;
    assign ns_mask_lvl = ns_split ? HALF : '0;

    function automatic eprio_t widen(input logic [PRIO_W-1:0] v);
        return eprio_t'({2'b00, v});
    endfunction

    for (genvar i = 0; i < N_CAND; i++) begin : g_cand
        eprio_t c_val;
        logic   c_on;

        always_comb begin
            unique case (cand_kind_e'(i))
                K_THR_NS: begin
                    c_val = widen(mapped_ns);
                    c_on  = |thr_ns;
                end
                K_THR_S: begin
                    c_val = widen(gthr_s);
                    c_on  = |thr_s;
                end
                K_IMASK_NS: begin
                    c_val = widen(ns_mask_lvl);
                    c_on  = imask_ns;
                end
                K_IMASK_S: begin
                    c_val = '0;
                    c_on  = imask_s;
                end
                K_FLT_NS: begin
                    c_val = ns_fault_own ? eprio_t'(-1) : widen(ns_mask_lvl);
                    c_on  = fltmask_ns;
                end
                K_FLT_S: begin
                    c_val = ns_fault_own ? eprio_t'(-3) : eprio_t'(-1);
                    c_on  = fltmask_s;
                end
                default: begin
                    c_val = IDLE_PRIO;
                    c_on  = 1'b0;
                end
            endcase
        end

        assign cand[i] = c_val;
        assign live[i] = c_on;
    end

endmodule

// File: rtl/epc_override_stage.sv
module epc_override_stage
    import epc_pkg::*;
(
    input  eprio_t run_in,
    input  eprio_t cand,
    input  logic   live,
    output eprio_t run_out
);

    // replace only with a strictly more urgent value
    assign run_out = (live && (cand < run_in)) ? cand : run_in;

endmodule

// File: rtl/exec_prio_calc.sv
module exec_prio_calc
    import epc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [RES_W-1:0] act_prio,
    input  logic [PRIO_W-1:0]       thr_s,
    input  logic [PRIO_W-1:0]       thr_ns,
    input  logic                    imask_s,
    input  logic                    imask_ns,
    input  logic                    fltmask_s,
    input  logic                    fltmask_ns,
    input  logic                    ns_split,
    input  logic                    ns_fault_own,
    input  logic [GRP_W-1:0]        grp_s,
    input  logic [GRP_W-1:0]        grp_ns,
    input  logic signed [RES_W-1:0] pend_prio,
    output logic signed [RES_W-1:0] exec_prio,
    output logic                    preempt
);

    eprio_t            cand [N_CAND];
    logic [N_CAND-1:0] live;
    eprio_t            run  [N_CAND+1];
    eprio_t            exec_d;
    logic              preempt_d;
    eprio_t            exec_q;
    logic              preempt_q;

    epc_candidates u_cand (
        .thr_s        (thr_s),
        .thr_ns       (thr_ns),
        .imask_s      (imask_s),
        .imask_ns     (imask_ns),
        .fltmask_s    (fltmask_s),
        .fltmask_ns   (fltmask_ns),
        .ns_split     (ns_split),
        .ns_fault_own (ns_fault_own),
        .grp_s        (grp_s),
        .grp_ns       (grp_ns),
        .cand         (cand),
        .live         (live)
    );

    assign run[0] = act_prio;

    for (genvar i = 0; i < N_CAND; i++) begin : g_chain
        epc_override_stage u_stage (
            .run_in  (run[i]),
            .cand    (cand[i]),
            .live    (live[i]),
            .run_out (run[i+1])
        );
    end

    assign exec_d    = run[N_CAND];
    assign preempt_d = pend_prio < exec_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_q    <= IDLE_PRIO;
            preempt_q <= 1'b0;
        end else begin
            exec_q    <= exec_d;
            preempt_q <= preempt_d;
        end
    end

    assign exec_prio = exec_q;
    assign preempt   = preempt_q;

endmodule

// File: rtl/exec_prio_calc_chk.sv
module exec_prio_calc_chk
    import epc_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic signed [RES_W-1:0] act_prio,
    input logic                    imask_s,
    input logic                    fltmask_s,
    input logic                    fltmask_ns,
    input logic                    ns_fault_own,
    input logic signed [RES_W-1:0] pend_prio,
    input logic signed [RES_W-1:0] exec_prio,
    input logic                    preempt
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_NEVER_LESS_URGENT: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (exec_prio <= $past(act_prio))); // R8

    AST_SFLT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(fltmask_s && ns_fault_own)) |-> (exec_prio == -3)); // R6

    AST_SFLT_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(fltmask_s && !ns_fault_own)) |-> (exec_prio <= -1)); // R6

    AST_NSFLT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(fltmask_ns && ns_fault_own)) |-> (exec_prio <= -1)); // R7

    AST_SIMASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(imask_s)) |-> (exec_prio <= 0)); // R5

    AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (preempt == ($past(pend_prio) < exec_prio))); // R9

endmodule

bind exec_prio_calc exec_prio_calc_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .act_prio     (act_prio),
    .imask_s      (imask_s),
    .fltmask_s    (fltmask_s),
    .fltmask_ns   (fltmask_ns),
    .ns_fault_own (ns_fault_own),
    .pend_prio    (pend_prio),
    .exec_prio    (exec_prio),
    .preempt      (preempt)
);

// File: tb/sim_exec_prio_calc.sv
`timescale 1ns/1ps
module sim_exec_prio_calc;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic signed [9:0] act_prio = 10'sd256;
    logic [7:0]        thr_s = '0, thr_ns = '0;
    logic              imask_s = 0, imask_ns = 0, fltmask_s = 0, fltmask_ns = 0;
    logic              ns_split = 0, ns_fault_own = 0;
    logic [2:0]        grp_s = '0, grp_ns = '0;
    logic signed [9:0] pend_prio = 10'sd256;
    logic signed [9:0] exec_prio;
    logic              preempt;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int    qp[$];
    bit    qe[$];
    string qt[$];

    always #5 clk = ~clk;

    exec_prio_calc u0 (
        .clk(clk), .rst_n(rst_n), .act_prio(act_prio),
        .thr_s(thr_s), .thr_ns(thr_ns),
        .imask_s(imask_s), .imask_ns(imask_ns),
        .fltmask_s(fltmask_s), .fltmask_ns(fltmask_ns),
        .ns_split(ns_split), .ns_fault_own(ns_fault_own),
        .grp_s(grp_s), .grp_ns(grp_ns), .pend_prio(pend_prio),
        .exec_prio(exec_prio), .preempt(preempt)
    );

    function automatic int keep_of(input int g);
        return (255 << (g + 1)) & 255;
    endfunction

    // model: running value, replaced only by strictly more urgent candidates
    task automatic drive(input int act, input int ts, input int tn,
                         input bit is, input bit in_, input bit fs, input bit fn,
                         input bit sp, input bit own, input int gs, input int gn,
                         input int pend, input string ftag);
        int run;
        int v;
        string tag;
        @(negedge clk);
        act_prio = 10'(act); thr_s = 8'(ts); thr_ns = 8'(tn);
        imask_s = is; imask_ns = in_; fltmask_s = fs; fltmask_ns = fn;
        ns_split = sp; ns_fault_own = own; grp_s = 3'(gs); grp_ns = 3'(gn);
        pend_prio = 10'(pend);
        run = act; tag = "R2";
        if (tn != 0) begin
            v = tn & keep_of(gn);
            if (sp) v = (v >> 1) | 128;
            if (v < run) begin run = v; tag = sp ? "R4" : "R3"; end
        end
        if (ts != 0) begin
            v = ts & keep_of(gs);
            if (v < run) begin run = v; tag = "R3"; end
        end
        if (in_) begin v = sp ? 128 : 0; if (v < run) begin run = v; tag = "R5"; end end
        if (is)  begin v = 0;            if (v < run) begin run = v; tag = "R5"; end end
        if (fn)  begin v = own ? -1 : (sp ? 128 : 0); if (v < run) begin run = v; tag = "R7"; end end
        if (fs)  begin v = own ? -3 : -1; if (v < run) begin run = v; tag = "R6"; end end
        if (ftag != "") tag = ftag;
        qp.push_back(run);
        qe.push_back(pend < run);
        qt.push_back(tag);
    endtask

    // monitor: results are registered at the posedge after driving
    always @(posedge clk) begin
        #2;
        if (qp.size() > 0) begin
            int    ep;
            bit    ee;
            string et;
            ep = qp.pop_front();
            ee = qe.pop_front();
            et = qt.pop_front();
            checks++;
            if (int'(exec_prio) != ep) begin
                errors++;
                $display("FAIL %s exec_prio actual %0d expected %0d", et, int'(exec_prio), ep);
            end
            checks++;
            if (preempt != ee) begin
                errors++;
                $display("FAIL R9 preempt actual %0d expected %0d", preempt, ee);
            end
        end
    end

    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int bv[4];
        int av[3];
        int pv[4];
        int k;
        bv = '{0, 'h20, 'h71, 'hC3};
        av = '{256, 'h10, 'hA0};
        pv = '{-2, 'h50, 'h80, 255};
        k = 0;

        // R1: reset holds outputs while inputs are busy
        act_prio = 10'sd5; fltmask_s = 1; pend_prio = -10'sd4;
        repeat (3) @(negedge clk);
        checks++;
        if (int'(exec_prio) != 256 || preempt != 1'b0) begin
            errors++;
            $display("FAIL R1 reset actual %0d/%0d expected 256/0", int'(exec_prio), preempt);
        end
        fltmask_s = 0;
        rst_n = 1'b1;

        // directed cases
        drive('h33, 0, 0, 0,0,0,0, 0,0, 0,0, 256, "R2");
        drive(256, 'h47, 0, 0,0,0,0, 0,0, 3,0, 256, "R3");
        drive('h20, 0, 0, 0,0,0,0, 0,0, 3,0, 256, "R3");
        drive(256, 'h47, 0, 0,0,0,0, 0,0, 7,0, 256, "R3");
        drive(256, 0, 'h60, 0,0,0,0, 1,0, 0,1, 256, "R4");
        drive(256, 0, 'h60, 0,0,0,0, 0,0, 0,1, 256, "R3");
        drive(256, 0, 0, 0,1,0,0, 1,0, 0,0, 256, "R5");
        drive(256, 0, 0, 0,1,0,0, 0,0, 0,0, 256, "R5");
        drive(256, 0, 0, 1,0,0,0, 1,0, 0,0, 256, "R5");
        drive(256, 0, 0, 0,0,1,0, 0,1, 0,0, 256, "R6");
        drive(256, 0, 0, 0,0,1,0, 0,0, 0,0, 256, "R6");
        drive(256, 0, 0, 0,0,0,1, 0,1, 0,0, 256, "R7");
        drive(256, 0, 0, 0,0,0,1, 1,0, 0,0, 256, "R7");
        drive(256, 0, 0, 0,0,0,1, 0,0, 0,0, 256, "R7");
        drive(256, 'h40, 0, 0,1,0,0, 1,0, 0,0, 256, "R8");
        drive(-2, 0, 0, 0,0,1,0, 0,0, 0,0, 256, "R8");
        drive('h40, 0, 0, 0,0,0,0, 0,0, 0,0, 'h40, "R9");
        drive('h40, 0, 0, 0,0,0,0, 0,0, 0,0, 'h3F, "R9");
        drive(256, 0, 0, 0,0,0,0, 0,0, 0,0, 255, "R9");
        drive(256, 0, 0, 0,0,1,0, 0,1, 0,0, -2, "R9");

        // sweep of masks, controls, thresholds, groupings and active levels
        for (int m = 0; m < 16; m++)
            for (int c = 0; c < 4; c++)
                for (int i = 0; i < 4; i++)
                    for (int j = 0; j < 4; j++)
                        for (int a = 0; a < 3; a++)
                            for (int g = 0; g < 2; g++) begin
                                drive(av[a], bv[i], bv[j],
                                      m[0], m[1], m[2], m[3],
                                      c[0], c[1],
                                      g ? 7 : 2, g ? 0 : 5,
                                      pv[k % 4], "");
                                k++;
                            end

        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule